// File: doc/BRIEF.md
# Arbitrated Loop Port Arbiter

This block is the port controller of one node on a unidirectional ring. Every clock cycle it takes one symbol from the upstream neighbour and hands one symbol to the downstream neighbour. A symbol is a 3-bit kind plus a value word. The port lets its local user win the loop, open a connection to another node, stream data and close the connection again. It also answers when another node opens a connection to it. It passes unchanged any traffic that does not concern it, with one cycle of latency.

Arbitration uses the requester's own ARB symbol, which travels once around the ring. Any port that owns the loop rewrites a passing ARB to the fill value 0xF0. A port that is arbitrating replaces a lower-numbered ARB with its own and lets a higher-numbered one through, so the highest node number wins. A requester that sees its own ARB come back unchanged has won. It then sends OPN, waits for R_RDY, moves data and finally sends CLS. The responder echoes CLS back to the initiator, and the initiator absorbs it.

The controller has six states. MONITOR is the idle state, where the port forwards everything. ARBITRATE is entered from MONITOR when `req_open` is high. OPENING is entered from ARBITRATE when the port's own ARB returns. XFER is entered from OPENING on R_RDY. CLOSING is entered from XFER when `req_close` is high, or from OPENING when the port's own OPN returns unanswered. RESPOND is entered from MONITOR or ARBITRATE when an OPN addressed to this node arrives. CLOSING and RESPOND go back to MONITOR on CLS. ARBITRATE goes back to MONITOR when `req_open` drops.

Top module: `loop_port_arbiter`

## Requirements
- R1: After reset the port transmits IDLE (kind 0, value 0), `loop_owner`, `connected` and `responding` are low, and `snk_valid` is low.
- R2: In MONITOR each received symbol is transmitted unchanged one cycle later, unless it is an OPN addressed to this node. Kind codes are IDLE=0, ARB=1, OPN=2, R_RDY=3, CLS=4, DATA=5.
- R3: While arbitrating, the port behaves as follows. A received IDLE is replaced by ARB carrying `my_addr` (value = zero-extended address). A received ARB with a lower address is also replaced by ARB carrying `my_addr`. A received ARB with a higher address is forwarded unchanged.
- R4: When an arbitrating port receives ARB carrying its own address, it transmits OPN on the next cycle and raises `loop_owner`. The OPN value is `req_dest` in bits 6:0 and `req_fdx` in bit 7.
- R5: A port in OPENING, XFER or CLOSING replaces every received ARB with ARB(0xF0). An arbitrating port that receives ARB(0xF0) transmits its own ARB again.
- R6: An OPN whose bits 6:0 equal `my_addr`, received in MONITOR or ARBITRATE, is answered with R_RDY (value 0). The port then enters RESPOND, and `responding` and `connected` go high. Bit 7 of that OPN selects full duplex (1) or half duplex (0).
- R7: After R_RDY the initiator enters XFER and `connected` goes high. In each cycle where the incoming symbol is not ARB and `src_valid` is high, the port sends DATA carrying `src_data` and pulses `src_take`. Received DATA is presented one cycle later on `snk_valid`/`snk_data` and is not forwarded.
- R8: A responder always delivers received DATA to the sink. In half duplex it never takes local data, and received DATA is replaced by IDLE. In full duplex, local data takes the slot of received DATA.
- R9: When `req_close` is high in XFER, the initiator sends CLS and enters CLOSING. There it absorbs every symbol as IDLE. When CLS arrives it transmits IDLE and returns to MONITOR.
- R10: A responder that receives CLS transmits CLS and returns to MONITOR. A responder forwards received ARB, OPN and R_RDY unchanged.
- R11: If a port in OPENING receives an OPN (its own, unanswered), it sends CLS and enters CLOSING instead of waiting for R_RDY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| my_addr | input | ADDR_W | This node's loop address |
| rx_kind | input | 3 | Kind of the symbol from upstream |
| rx_val | input | DATA_W | Value of the symbol from upstream |
| req_open | input | 1 | Local request to win the loop (level) |
| req_dest | input | ADDR_W | Destination for the OPN |
| req_fdx | input | 1 | Full-duplex flag for the OPN |
| req_close | input | 1 | Local request to close the connection |
| src_valid | input | 1 | Local outgoing data is present |
| src_data | input | DATA_W | Local outgoing data word |
| src_take | output | 1 | Local data word is consumed at this clock edge |
| tx_kind | output | 3 | Kind of the symbol sent downstream |
| tx_val | output | DATA_W | Value of the symbol sent downstream |
| snk_valid | output | 1 | Received data word is valid |
| snk_data | output | DATA_W | Received data word |
| loop_owner | output | 1 | Port is in OPENING, XFER or CLOSING |
| connected | output | 1 | Port is in XFER or RESPOND |
| responding | output | 1 | Port is in RESPOND |

## Verification
The bench uses the default widths: a 7-bit address, an 8-bit value word and fill value 0xF0, which lies outside the address range. It drives `my_addr` at run time, so it can test a mid-range address (0x2A), the top address 0x7F and address 0. This covers the lower-versus-higher ARB comparison at both range edges, the fill-ARB retry, responders in half and full duplex, an OPN that arrives mid-arbitration, and an OPN that returns to its sender unanswered.

// File: rtl/lpa_pkg.sv
package lpa_pkg;

    typedef enum logic [2:0] {
        SYM_IDLE = 3'd0,
        SYM_ARB  = 3'd1,
        SYM_OPN  = 3'd2,
        SYM_RRDY = 3'd3,
        SYM_CLS  = 3'd4,
        SYM_DATA = 3'd5
    } sym_kind_e;

    typedef enum logic [2:0] {
        ST_MONITOR,
        ST_ARBITRATE,
        ST_OPENING,
        ST_XFER,
        ST_CLOSING,
        ST_RESPOND
    } lp_state_e;

    typedef enum logic [1:0] {
        ARB_FORWARD,
        ARB_REPLACE,
        ARB_WON
    } arb_verdict_e;

    typedef enum logic [2:0] {
        ACT_FWD,
        ACT_IDLE,
        ACT_OWN_ARB,
        ACT_FILL_ARB,
        ACT_OPN,
        ACT_RRDY,
        ACT_CLS,
        ACT_SRC_DATA
    } tx_act_e;

endpackage

// File: rtl/lpa_arb_judge.sv
module lpa_arb_judge
    import lpa_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int VAL_W  = 8
) (
    input  logic [VAL_W-1:0]  arb_val,
    input  logic [ADDR_W-1:0] my_addr,
    output arb_verdict_e      verdict
);
    localparam int HI_W = VAL_W - ADDR_W;

    logic in_range;
    logic is_mine;
    logic is_higher;

    always_comb begin
        in_range  = (arb_val[VAL_W-1:ADDR_W] == HI_W'(0));
        is_mine   = in_range && (arb_val[ADDR_W-1:0] == my_addr);
        is_higher = in_range && (arb_val[ADDR_W-1:0] > my_addr);
        if (is_mine) begin
            verdict = ARB_WON;
        end else if (is_higher) begin
            verdict = ARB_FORWARD;
        end else begin
            verdict = ARB_REPLACE;
        end
    end

endmodule

// File: rtl/lpa_ctrl.sv
module lpa_ctrl
    import lpa_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int VAL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sym_kind_e         rx_kind,
    input  logic [VAL_W-1:0]  rx_val,
    input  logic [ADDR_W-1:0] my_addr,
    input  arb_verdict_e      verdict,
    input  logic              req_open,
    input  logic              req_close,
    input  logic              src_valid,
    output lp_state_e         state_q,
    output tx_act_e           act,
    output logic              deliver,
    output logic              take
);
    localparam int FDX_BIT = VAL_W - 1;

    lp_state_e state_d;
    logic      fdx_q;
    logic      fdx_d;
    logic      opn_for_me;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_MONITOR;
            fdx_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            fdx_q   <= fdx_d;
        end
    end

    always_comb begin
        opn_for_me = (rx_kind == SYM_OPN) && (rx_val[ADDR_W-1:0] == my_addr);
        state_d    = state_q;
        fdx_d      = fdx_q;
        act        = ACT_FWD;
        deliver    = 1'b0;
        take       = 1'b0;
        unique case (state_q)
            ST_MONITOR: begin
                if (opn_for_me) begin
                    act     = ACT_RRDY;
                    state_d = ST_RESPOND;
                    fdx_d   = rx_val[FDX_BIT];
                end else if (req_open) begin
                    state_d = ST_ARBITRATE;
                end
            end
            ST_ARBITRATE: begin
                if (opn_for_me) begin
                    act     = ACT_RRDY;
                    state_d = ST_RESPOND;
                    fdx_d   = rx_val[FDX_BIT];
                end else if (!req_open) begin
                    state_d = ST_MONITOR;
                end else if (rx_kind == SYM_ARB) begin
                    unique case (verdict)
                        ARB_WON: begin
                            act     = ACT_OPN;
                            state_d = ST_OPENING;
                        end
                        ARB_FORWARD: act = ACT_FWD;
                        default:     act = ACT_OWN_ARB;
                    endcase
                end else if (rx_kind == SYM_IDLE) begin
                    act = ACT_OWN_ARB;
                end
            end
            ST_OPENING: begin
                act = ACT_IDLE;
                if (rx_kind == SYM_ARB) begin
                    act = ACT_FILL_ARB;
                end else if (rx_kind == SYM_RRDY) begin
                    state_d = ST_XFER;
                end else if (rx_kind == SYM_OPN) begin
                    act     = ACT_CLS;
                    state_d = ST_CLOSING;
                end
            end
            ST_XFER: begin
                act = ACT_IDLE;
                if (rx_kind == SYM_ARB) begin
                    act = ACT_FILL_ARB;
                end else if (req_close) begin
                    act     = ACT_CLS;
                    state_d = ST_CLOSING;
                end else begin
                    deliver = (rx_kind == SYM_DATA);
                    if (src_valid) begin
                        act  = ACT_SRC_DATA;
                        take = 1'b1;
                    end
                end
            end
            ST_CLOSING: begin
                act = ACT_IDLE;
                if (rx_kind == SYM_ARB) begin
                    act = ACT_FILL_ARB;
                end else if (rx_kind == SYM_CLS) begin
                    state_d = ST_MONITOR;
                end
            end
            ST_RESPOND: begin
                if (rx_kind == SYM_CLS) begin
                    act     = ACT_CLS;
                    state_d = ST_MONITOR;
                end else if (rx_kind == SYM_DATA || rx_kind == SYM_IDLE) begin
                    deliver = (rx_kind == SYM_DATA);
                    act     = (rx_kind == SYM_DATA) ? ACT_IDLE : ACT_FWD;
                    if (fdx_q && src_valid) begin
                        act  = ACT_SRC_DATA;
                        take = 1'b1;
                    end
                end
            end
            default: begin
                state_d = ST_MONITOR;
            end
        endcase
    end

    // R8: a half-duplex responder never consumes local data
    a_r8_half_no_take: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESPOND && !fdx_q) |-> !take);

    // R9: a returning CLS ends the close sequence
    a_r9_close_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLOSING && rx_kind == SYM_CLS) |=> (state_q == ST_MONITOR));

    // R7: data flows only while connected
    a_r7_take_when_connected: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (state_q == ST_XFER || state_q == ST_RESPOND));

endmodule

// File: rtl/lpa_tx_stage.sv
module lpa_tx_stage
    import lpa_pkg::*;
#(
    parameter int                ADDR_W   = 7,
    parameter int                VAL_W    = 8,
    parameter logic [VAL_W-1:0]  FILL_VAL = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tx_act_e           act,
    input  logic              deliver,
    input  sym_kind_e         rx_kind,
    input  logic [VAL_W-1:0]  rx_val,
    input  logic [ADDR_W-1:0] my_addr,
    input  logic [ADDR_W-1:0] req_dest,
    input  logic              req_fdx,
    input  logic [VAL_W-1:0]  src_data,
    output sym_kind_e         tx_kind_q,
    output logic [VAL_W-1:0]  tx_val_q,
    output logic              snk_valid_q,
    output logic [VAL_W-1:0]  snk_data_q
);
    sym_kind_e        kind_d;
    logic [VAL_W-1:0] val_d;
    logic [VAL_W-1:0] opn_word;

    always_comb begin
        opn_word              = '0;
        opn_word[ADDR_W-1:0]  = req_dest;
        opn_word[VAL_W-1]     = req_fdx;
        kind_d = SYM_IDLE;
        val_d  = '0;
        unique case (act)
            ACT_FWD: begin
                kind_d = rx_kind;
                val_d  = rx_val;
            end
            ACT_IDLE: begin
                kind_d = SYM_IDLE;
            end
            ACT_OWN_ARB: begin
                kind_d = SYM_ARB;
                val_d  = VAL_W'(my_addr);
            end
            ACT_FILL_ARB: begin
                kind_d = SYM_ARB;
                val_d  = FILL_VAL;
            end
            ACT_OPN: begin
                kind_d = SYM_OPN;
                val_d  = opn_word;
            end
            ACT_RRDY: begin
                kind_d = SYM_RRDY;
            end
            ACT_CLS: begin
                kind_d = SYM_CLS;
            end
            ACT_SRC_DATA: begin
                kind_d = SYM_DATA;
                val_d  = src_data;
            end
            default: begin
                kind_d = SYM_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_kind_q   <= SYM_IDLE;
            tx_val_q    <= '0;
            snk_valid_q <= 1'b0;
            snk_data_q  <= '0;
        end else begin
            tx_kind_q   <= kind_d;
            tx_val_q    <= val_d;
            snk_valid_q <= deliver;
            snk_data_q  <= deliver ? rx_val : snk_data_q;
        end
    end

endmodule

// File: rtl/loop_port_arbiter.sv
module loop_port_arbiter
    import lpa_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int DATA_W    = 8,
    parameter int FILL_CODE = 'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] my_addr,
    input  logic [2:0]        rx_kind,
    input  logic [DATA_W-1:0] rx_val,
    input  logic              req_open,
    input  logic [ADDR_W-1:0] req_dest,
    input  logic              req_fdx,
    input  logic              req_close,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_take,
    output logic [2:0]        tx_kind,
    output logic [DATA_W-1:0] tx_val,
    output logic              snk_valid,
    output logic [DATA_W-1:0] snk_data,
    output logic              loop_owner,
    output logic              connected,
    output logic              responding
);
    // The value word carries an address plus the duplex flag above it.
    localparam int               VAL_W    = DATA_W;
    localparam logic [VAL_W-1:0] FILL_VAL = VAL_W'(FILL_CODE);

    sym_kind_e    rx_kind_e;
    sym_kind_e    tx_kind_e;
    arb_verdict_e verdict;
    lp_state_e    state;
    tx_act_e      act;
    logic         deliver;

    assign rx_kind_e = sym_kind_e'(rx_kind);

    lpa_arb_judge #(.ADDR_W(ADDR_W), .VAL_W(VAL_W)) judge_i (
        .arb_val (rx_val),
        .my_addr (my_addr),
        .verdict (verdict)
    );

    lpa_ctrl #(.ADDR_W(ADDR_W), .VAL_W(VAL_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_kind   (rx_kind_e),
        .rx_val    (rx_val),
        .my_addr   (my_addr),
        .verdict   (verdict),
        .req_open  (req_open),
        .req_close (req_close),
        .src_valid (src_valid),
        .state_q   (state),
        .act       (act),
        .deliver   (deliver),
        .take      (src_take)
    );

    lpa_tx_stage #(.ADDR_W(ADDR_W), .VAL_W(VAL_W), .FILL_VAL(FILL_VAL)) tx_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .act         (act),
        .deliver     (deliver),
        .rx_kind     (rx_kind_e),
        .rx_val      (rx_val),
        .my_addr     (my_addr),
        .req_dest    (req_dest),
        .req_fdx     (req_fdx),
        .src_data    (src_data),
        .tx_kind_q   (tx_kind_e),
        .tx_val_q    (tx_val),
        .snk_valid_q (snk_valid),
        .snk_data_q  (snk_data)
    );

    assign tx_kind    = tx_kind_e;
    assign loop_owner = (state == ST_OPENING) || (state == ST_XFER) || (state == ST_CLOSING);
    assign connected  = (state == ST_XFER) || (state == ST_RESPOND);
    assign responding = (state == ST_RESPOND);

    // R5: an owner never lets a foreign ARB pass
    a_r5_owner_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_owner && rx_kind == 3'd1) |=> (tx_kind == 3'd1 && tx_val == FILL_VAL));

    // R2: idle monitoring is transparent with one cycle of latency
    a_r2_monitor_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MONITOR && !(rx_kind == 3'd2 && rx_val[ADDR_W-1:0] == my_addr))
        |=> (tx_kind == $past(rx_kind) && tx_val == $past(rx_val)));

    // R4: own ARB returning while requesting yields OPN and ownership
    a_r4_win_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARBITRATE && req_open && rx_kind == 3'd1 && rx_val == VAL_W'(my_addr))
        |=> (tx_kind == 3'd2 && loop_owner));

    // R10: responder echoes CLS and drops the connection
    a_r10_resp_close: assert property (@(posedge clk) disable iff (!rst_n)
        (responding && rx_kind == 3'd4) |=> (tx_kind == 3'd4 && !connected));

    // R6: initiator and responder roles are exclusive
    a_r6_roles_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({loop_owner, responding}));

endmodule

// File: tb/loop_port_arbiter_tb_top.sv
module loop_port_arbiter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    localparam logic [2:0] K_IDLE = 3'd0;
    localparam logic [2:0] K_ARB  = 3'd1;
    localparam logic [2:0] K_OPN  = 3'd2;
    localparam logic [2:0] K_RRDY = 3'd3;
    localparam logic [2:0] K_CLS  = 3'd4;
    localparam logic [2:0] K_DATA = 3'd5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] my_addr = 7'h2A;
    logic [2:0] rx_kind = K_IDLE;
    logic [7:0] rx_val = 8'h00;
    logic       req_open = 1'b0;
    logic [6:0] req_dest = 7'h00;
    logic       req_fdx = 1'b0;
    logic       req_close = 1'b0;
    logic       src_valid = 1'b0;
    logic [7:0] src_data = 8'h00;
    logic       src_take;
    logic [2:0] tx_kind;
    logic [7:0] tx_val;
    logic       snk_valid;
    logic [7:0] snk_data;
    logic       loop_owner;
    logic       connected;
    logic       responding;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;
    logic take_seen;

    always #(CLK_PERIOD/2) clk = ~clk;

    loop_port_arbiter dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .my_addr    (my_addr),
        .rx_kind    (rx_kind),
        .rx_val     (rx_val),
        .req_open   (req_open),
        .req_dest   (req_dest),
        .req_fdx    (req_fdx),
        .req_close  (req_close),
        .src_valid  (src_valid),
        .src_data   (src_data),
        .src_take   (src_take),
        .tx_kind    (tx_kind),
        .tx_val     (tx_val),
        .snk_valid  (snk_valid),
        .snk_data   (snk_data),
        .loop_owner (loop_owner),
        .connected  (connected),
        .responding (responding)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_tx(input string tag, input logic [2:0] k, input logic [7:0] v);
        chk(tag, {21'd0, tx_kind, tx_val}, {21'd0, k, v});
    endtask

    // Present one symbol at a falling edge; return at the next falling edge,
    // where the registered response to that symbol is visible.
    task automatic sym(input logic [2:0] k, input logic [7:0] v);
        rx_kind = k;
        rx_val  = v;
        #1;
        take_seen = src_take;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk_tx("R1 reset tx idle", K_IDLE, 8'h00);
        chk("R1 reset flags", {29'd0, loop_owner, connected, responding}, 32'd0);
        chk("R1 reset sink", {31'd0, snk_valid}, 32'd0);
    endtask

    task automatic t_forward();
        sym(K_ARB, 8'h10);  chk_tx("R2 fwd ARB", K_ARB, 8'h10);
        sym(K_OPN, 8'h11);  chk_tx("R2 fwd OPN other", K_OPN, 8'h11);
        sym(K_RRDY, 8'h00); chk_tx("R2 fwd R_RDY", K_RRDY, 8'h00);
        sym(K_DATA, 8'h5C); chk_tx("R2 fwd DATA", K_DATA, 8'h5C);
        sym(K_CLS, 8'h00);  chk_tx("R2 fwd CLS", K_CLS, 8'h00);
        sym(K_IDLE, 8'h00); chk_tx("R2 fwd IDLE", K_IDLE, 8'h00);
    endtask

    task automatic t_initiator();
        my_addr = 7'h2A; req_dest = 7'h11; req_fdx = 1'b1; req_open = 1'b1;
        sym(K_IDLE, 8'h00); chk_tx("R2 request cycle forwards", K_IDLE, 8'h00);
        sym(K_IDLE, 8'h00); chk_tx("R3 idle replaced by own ARB", K_ARB, 8'h2A);
        sym(K_ARB, 8'h05);  chk_tx("R3 lower ARB replaced", K_ARB, 8'h2A);
        sym(K_ARB, 8'h50);  chk_tx("R3 higher ARB forwarded", K_ARB, 8'h50);
        sym(K_ARB, 8'hF0);  chk_tx("R5 fill ARB retried", K_ARB, 8'h2A);
        sym(K_DATA, 8'h33); chk_tx("R3 foreign data forwarded", K_DATA, 8'h33);
        sym(K_ARB, 8'h2A);  chk_tx("R4 win sends OPN", K_OPN, 8'h91);
        chk("R4 owner raised", {31'd0, loop_owner}, 32'd1);
        req_open = 1'b0;
        sym(K_ARB, 8'h60);  chk_tx("R5 owner fills ARB", K_ARB, 8'hF0);
        sym(K_RRDY, 8'h00); chk_tx("R7 R_RDY absorbed", K_IDLE, 8'h00);
        chk("R7 connected", {31'd0, connected}, 32'd1);
        src_valid = 1'b1; src_data = 8'hA5;
        sym(K_IDLE, 8'h00);
        chk("R7 take on free slot", {31'd0, take_seen}, 32'd1);
        chk_tx("R7 local data sent", K_DATA, 8'hA5);
        src_data = 8'hB6;
        sym(K_DATA, 8'h3C);
        chk_tx("R7 data replaces received", K_DATA, 8'hB6);
        chk("R7 sink gets data", {23'd0, snk_valid, snk_data}, {23'd0, 1'b1, 8'h3C});
        sym(K_ARB, 8'h70);
        chk("R7 no take on ARB slot", {31'd0, take_seen}, 32'd0);
        chk_tx("R5 fill during transfer", K_ARB, 8'hF0);
        src_valid = 1'b0; req_close = 1'b1;
        sym(K_IDLE, 8'h00); chk_tx("R9 close sends CLS", K_CLS, 8'h00);
        req_close = 1'b0;
        sym(K_DATA, 8'h11); chk_tx("R9 closing absorbs", K_IDLE, 8'h00);
        chk("R9 still owner", {31'd0, loop_owner}, 32'd1);
        sym(K_CLS, 8'h00);  chk_tx("R9 returning CLS absorbed", K_IDLE, 8'h00);
        chk("R9 ownership released", {30'd0, loop_owner, connected}, 32'd0);
        sym(K_DATA, 8'h44); chk_tx("R2 forwards after release", K_DATA, 8'h44);
    endtask

    task automatic t_resp_half();
        sym(K_OPN, 8'h2A);  chk_tx("R6 OPN answered R_RDY", K_RRDY, 8'h00);
        chk("R6 responder flags", {30'd0, responding, connected}, 32'd3);
        src_valid = 1'b1; src_data = 8'h99;
        sym(K_DATA, 8'h12);
        chk("R8 half duplex no take", {31'd0, take_seen}, 32'd0);
        chk_tx("R8 half duplex sends idle", K_IDLE, 8'h00);
        chk("R8 half duplex delivers", {23'd0, snk_valid, snk_data}, {23'd0, 1'b1, 8'h12});
        sym(K_ARB, 8'h05);  chk_tx("R10 responder forwards ARB", K_ARB, 8'h05);
        sym(K_CLS, 8'h00);  chk_tx("R10 CLS echoed", K_CLS, 8'h00);
        chk("R10 responder done", {30'd0, responding, connected}, 32'd0);
        src_valid = 1'b0;
    endtask

    task automatic t_resp_full();
        sym(K_OPN, 8'hAA);  chk_tx("R6 full duplex OPN", K_RRDY, 8'h00);
        src_valid = 1'b1; src_data = 8'h77;
        sym(K_DATA, 8'h21);
        chk("R8 full duplex take", {31'd0, take_seen}, 32'd1);
        chk_tx("R8 full duplex data out", K_DATA, 8'h77);
        chk("R8 full duplex delivers", {23'd0, snk_valid, snk_data}, {23'd0, 1'b1, 8'h21});
        src_valid = 1'b0;
        sym(K_CLS, 8'h00);  chk_tx("R10 full duplex close", K_CLS, 8'h00);
    endtask

    task automatic t_opn_during_arb();
        req_open = 1'b1; req_dest = 7'h01; req_fdx = 1'b0;
        sym(K_IDLE, 8'h00);
        sym(K_OPN, 8'h2A);  chk_tx("R6 OPN wins over arbitration", K_RRDY, 8'h00);
        chk("R6 responder not owner", {30'd0, responding, loop_owner}, 32'd2);
        req_open = 1'b0;
        sym(K_CLS, 8'h00);  chk_tx("R10 close after pre-empt", K_CLS, 8'h00);
        sym(K_IDLE, 8'h00); chk_tx("R2 idle after request dropped", K_IDLE, 8'h00);
    endtask

    task automatic t_unanswered_top();
        my_addr = 7'h7F; req_open = 1'b1; req_dest = 7'h03; req_fdx = 1'b0;
        sym(K_IDLE, 8'h00);
        sym(K_ARB, 8'h7E);  chk_tx("R3 top address replaces 0x7E", K_ARB, 8'h7F);
        sym(K_ARB, 8'h7F);  chk_tx("R4 top address OPN half", K_OPN, 8'h03);
        req_open = 1'b0;
        sym(K_OPN, 8'h03);  chk_tx("R11 unanswered OPN closes", K_CLS, 8'h00);
        sym(K_CLS, 8'h00);  chk_tx("R9 CLS absorbed", K_IDLE, 8'h00);
        chk("R11 released", {31'd0, loop_owner}, 32'd0);
    endtask

    task automatic t_addr_zero();
        my_addr = 7'h00; req_open = 1'b1; req_dest = 7'h05; req_fdx = 1'b1;
        sym(K_IDLE, 8'h00);
        sym(K_ARB, 8'h01);  chk_tx("R3 address 0 forwards 0x01", K_ARB, 8'h01);
        sym(K_ARB, 8'h00);  chk_tx("R4 address 0 wins", K_OPN, 8'h85);
        req_open = 1'b0;
        sym(K_OPN, 8'h85);  chk_tx("R11 address 0 closes", K_CLS, 8'h00);
        sym(K_CLS, 8'h00);
        chk("R9 address 0 released", {31'd0, loop_owner}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_forward();
        t_initiator();
        t_resp_half();
        t_resp_full();
        t_opn_during_arb();
        t_unanswered_top();
        t_addr_zero();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired after %0d cycles", WD_CYCLES);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule